// File: doc/BRIEF.md
# HI/LO Multiply-Divide Register Unit

This block is the side unit of a small 32-bit RISC core that owns the two special result registers, HI and LO. It runs an unsigned multiply and an unsigned restoring divide, accepts direct moves of an operand into either register, and returns either register on a read port. Once a multiply or divide is issued, the unit holds a busy line high until the result has landed. While busy, the core stalls every issue, including reads.

The unit also follows the usage rules around these registers. A finished arithmetic result stays "unread" until either register is read. If software overwrites one half with a move before that read, the other half is marked undefined, and any later read of that half returns an undefined flag with the data. Divide by zero completes in normal time with defined bit patterns and sets the undefined flag on both halves. A build-time legacy option flags any write to HI/LO that comes within two instructions after a read of either register.

Top module: `hilo_unit`

## Requirements
- R1: `op_i` codes are 0 no-op, 1 unsigned multiply, 2 unsigned divide, 3 move to HI, 4 move to LO, 5 read HI, 6 read LO. An issue is accepted on a rising clock edge with `issue_i` high and `busy_o` low, and every accepted issue (no-op included) counts as one instruction. Reset (synchronous, active high) clears HI, LO, the unread-result state, both undefined flags, the read history, `busy_o`, `rd_valid_o` and `hazard_o`.
- R2: A multiply leaves the low half of the 64-bit product of `src_a_i` and `src_b_i` in LO and the high half in HI.
- R3: A divide leaves `src_a_i / src_b_i` in LO and `src_a_i % src_b_i` in HI. It keeps `busy_o` high for exactly W cycles after acceptance.
- R4: A move copies `src_a_i` unchanged into the chosen register and clears that register's undefined flag.
- R5: An accepted read drives `rd_valid_o` high in the next cycle, with the register value on `rd_data_o` and its undefined flag on `rd_undef_o`. Any read marks a pending arithmetic result as consumed.
- R6: A move to HI made while an arithmetic result is still unread marks LO undefined.
- R7: A move to LO made while an arithmetic result is still unread marks HI undefined.
- R8: A move made after the pending result has been read marks nothing undefined.
- R9: A divide by zero takes the same W cycles. It leaves all ones in LO and the dividend in HI, and marks both undefined.
- R10: No issue is accepted while `busy_o` is high. A read held through a busy period is accepted in the first cycle after busy falls and returns the new result.
- R11: With LEGACY=1, a write (multiply, divide or either move) accepted when one of the two previously accepted issues was a read raises `hazard_o` for one cycle. With LEGACY=0, `hazard_o` stays low.
- R12: A multiply keeps `busy_o` high for 1 cycle when MUL_ITERATIVE=0 and for W cycles when MUL_ITERATIVE=1, with the same acceptance rule as a divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Operation request |
| op_i | input | 3 | Operation code (see R1) |
| src_a_i | input | W | First operand: multiplicand, dividend or move source |
| src_b_i | input | W | Second operand: multiplier or divisor |
| busy_o | output | 1 | Arithmetic in progress; issues are stalled |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | W | Value of the register read |
| rd_undef_o | output | 1 | Returned value is undefined |
| hazard_o | output | 1 | Legacy read-to-write spacing violation |

## Verification
The bench builds two copies side by side, both with W=32. One has LEGACY=1 and MUL_ITERATIVE=1; the other has LEGACY=0 and the single-cycle multiplier. Both run the same stimulus, so one run covers both multiplier variants: their different busy lengths for a multiply and their equal W-cycle divide. It also shows, at the ports, that the spacing check fires only in the legacy copy. The 32-bit width brings full-range carries within reach, such as all-ones times all-ones, as well as the all-ones quotient of a zero divisor.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_MULU  = 3'd1,
        OP_DIVU  = 3'd2,
        OP_SETHI = 3'd3,
        OP_SETLO = 3'd4,
        OP_GETHI = 3'd5,
        OP_GETLO = 3'd6
    } hilo_op_e;

    typedef struct packed {
        logic pending;
        logic hi_undef;
        logic lo_undef;
    } hilo_flags_t;

    function automatic logic op_is_read(hilo_op_e op);
        return (op == OP_GETHI) || (op == OP_GETLO);
    endfunction

    function automatic logic op_is_write(hilo_op_e op);
        return (op == OP_MULU) || (op == OP_DIVU) ||
               (op == OP_SETHI) || (op == OP_SETLO);
    endfunction

endpackage

// File: rtl/hilo_div.sv
module hilo_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         zero_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] ITER = CW'(W);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic          zero_q;
    logic [W:0]    rem_sh, diff;
    logic          fits;

    // one restoring step: shift in next dividend bit, trial subtract
    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        diff   = rem_sh - {1'b0, dvs_q};
        fits   = ~diff[W];
        rem_o  = fits ? diff[W-1:0] : rem_sh[W-1:0];
        quo_o  = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            zero_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= ITER;
            rem_q  <= '0;
            quo_q  <= dividend_i;
            dvs_q  <= divisor_i;
            zero_q <= (divisor_i == '0);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            rem_q <= rem_o;
            quo_q <= quo_o;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));
    assign zero_o = zero_q;

endmodule

// File: rtl/hilo_mul.sv
module hilo_mul #(
    parameter int W         = 32,
    parameter bit ITERATIVE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] prod_o
);
    localparam int CW = $clog2(W + 1);

    generate
        if (ITERATIVE) begin : g_iter
            localparam logic [CW-1:0] ITER = CW'(W);
            logic [CW-1:0]  cnt_q;
            logic [2*W-1:0] acc_q;
            logic [W-1:0]   mcand_q;
            logic [W:0]     sum;

            // shift-add: add multiplicand to upper half when LSB set, shift right
            always_comb begin
                sum    = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
                prod_o = {sum, acc_q[W-1:1]};
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q   <= '0;
                    acc_q   <= '0;
                    mcand_q <= '0;
                end else if (start_i) begin
                    cnt_q   <= ITER;
                    acc_q   <= {{W{1'b0}}, a_i};
                    mcand_q <= b_i;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                    acc_q <= prod_o;
                end
            end

            assign busy_o = (cnt_q != '0);
            assign done_o = (cnt_q == CW'(1));
        end else begin : g_fast
            logic         run_q;
            logic [W-1:0] a_q, b_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    run_q <= 1'b0;
                    a_q   <= '0;
                    b_q   <= '0;
                end else begin
                    run_q <= start_i;
                    if (start_i) begin
                        a_q <= a_i;
                        b_q <= b_i;
                    end
                end
            end

            assign prod_o = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};
            assign busy_o = run_q;
            assign done_o = run_q;
        end
    endgenerate

endmodule

// File: rtl/hilo_hazard.sv
module hilo_hazard
    import hilo_pkg::*;
#(
    parameter bit LEGACY = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_i,
    input  hilo_op_e op_i,
    output logic     hazard_o
);
    // hist_q[0]: previous accepted issue was a read; hist_q[1]: the one before
    logic [1:0] hist_q;
    logic       hazard_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q   <= '0;
            hazard_q <= 1'b0;
        end else begin
            hazard_q <= LEGACY && accept_i && op_is_write(op_i) && (|hist_q);
            if (accept_i)
                hist_q <= {hist_q[0], op_is_read(op_i)};
        end
    end

    assign hazard_o = hazard_q;

endmodule

// File: rtl/hilo_unit.sv
module hilo_unit
    import hilo_pkg::*;
#(
    parameter int W             = 32,
    parameter bit LEGACY        = 1'b1,
    parameter bit MUL_ITERATIVE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         issue_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] src_a_i,
    input  logic [W-1:0] src_b_i,
    output logic         busy_o,
    output logic         rd_valid_o,
    output logic [W-1:0] rd_data_o,
    output logic         rd_undef_o,
    output logic         hazard_o
);
    hilo_op_e       op;
    logic           accept;
    logic           mul_busy, mul_done, div_busy, div_done, div_zero;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo, rem;
    logic [W-1:0]   hi_q, lo_q;
    hilo_flags_t    flg_q;

    assign op     = hilo_op_e'(op_i);
    assign busy_o = mul_busy | div_busy;
    assign accept = issue_i & ~busy_o;

    hilo_mul #(.W(W), .ITERATIVE(MUL_ITERATIVE)) mul_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (accept && op == OP_MULU),
        .a_i     (src_a_i),
        .b_i     (src_b_i),
        .busy_o  (mul_busy),
        .done_o  (mul_done),
        .prod_o  (prod)
    );

    hilo_div #(.W(W)) div_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (accept && op == OP_DIVU),
        .dividend_i (src_a_i),
        .divisor_i  (src_b_i),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .zero_o     (div_zero),
        .quo_o      (quo),
        .rem_o      (rem)
    );

    hilo_hazard #(.LEGACY(LEGACY)) haz_i (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .op_i     (op),
        .hazard_o (hazard_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q       <= '0;
            lo_q       <= '0;
            flg_q      <= '0;
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            rd_undef_o <= 1'b0;
        end else begin
            rd_valid_o <= 1'b0;
            if (mul_done) begin
                {hi_q, lo_q}   <= prod;
                flg_q.hi_undef <= 1'b0;
                flg_q.lo_undef <= 1'b0;
                flg_q.pending  <= 1'b1;
            end else if (div_done) begin
                lo_q           <= quo;
                hi_q           <= rem;
                flg_q.hi_undef <= div_zero;
                flg_q.lo_undef <= div_zero;
                flg_q.pending  <= 1'b1;
            end else if (accept) begin
                case (op)
                    OP_SETHI: begin
                        hi_q           <= src_a_i;
                        flg_q.hi_undef <= 1'b0;
                        if (flg_q.pending) flg_q.lo_undef <= 1'b1;
                        flg_q.pending  <= 1'b0;
                    end
                    OP_SETLO: begin
                        lo_q           <= src_a_i;
                        flg_q.lo_undef <= 1'b0;
                        if (flg_q.pending) flg_q.hi_undef <= 1'b1;
                        flg_q.pending  <= 1'b0;
                    end
                    OP_GETHI: begin
                        rd_valid_o    <= 1'b1;
                        rd_data_o     <= hi_q;
                        rd_undef_o    <= flg_q.hi_undef;
                        flg_q.pending <= 1'b0;
                    end
                    OP_GETLO: begin
                        rd_valid_o    <= 1'b1;
                        rd_data_o     <= lo_q;
                        rd_undef_o    <= flg_q.lo_undef;
                        flg_q.pending <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/hilo_unit_chk.sv
module hilo_unit_chk
    import hilo_pkg::*;
#(
    parameter int W      = 32,
    parameter bit LEGACY = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       issue_i,
    input logic [2:0] op_i,
    input logic       busy_o,
    input logic       rd_valid_o,
    input logic       hazard_o
);
    localparam int LW = $clog2(W + 2) + 1;
    logic [LW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) busy_len <= '0;
        else                busy_len <= busy_len + 1'b1;
    end

    // R5: read data appears only after an accepted read
    a_r5_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> $past(issue_i && !busy_o && op_is_read(hilo_op_e'(op_i))));

    // R10: nothing accepted while busy, so no read data the cycle after
    a_r10_stall_blocks_read: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !rd_valid_o);

    // R11: hazard only follows an accepted write, and only in legacy builds
    a_r11_hazard_after_write: assert property (@(posedge clk) disable iff (rst)
        hazard_o |-> (LEGACY && $past(issue_i && !busy_o && op_is_write(hilo_op_e'(op_i)))));

    // R12: busy only starts from an issued multiply or divide
    a_r12_busy_from_arith: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(issue_i && (op_i == OP_MULU || op_i == OP_DIVU)));

    // R3: a busy period never exceeds W cycles
    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy_len <= LW'(W));

endmodule

bind hilo_unit hilo_unit_chk #(.W(W), .LEGACY(LEGACY)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .issue_i    (issue_i),
    .op_i       (op_i),
    .busy_o     (busy_o),
    .rd_valid_o (rd_valid_o),
    .hazard_o   (hazard_o)
);

// File: tb/hilo_unit_tb_top.sv
`timescale 1ns/1ps
module hilo_unit_tb_top;
    import hilo_pkg::*;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         issue = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] a = '0, b = '0;

    logic         busy_a, rv_a, ru_a, hz_a;
    logic [W-1:0] rd_a;
    logic         busy_m, rv_m, ru_m, hz_m;
    logic [W-1:0] rd_m;

    int n_tests = 0;
    int n_fail  = 0;

    // captured at the negedge after each issue
    logic         c_rv_a, c_ru_a, c_hz_a, c_rv_m, c_ru_m, c_hz_m;
    logic [W-1:0] c_rd_a, c_rd_m;

    always #4 clk = ~clk;

    hilo_unit #(.W(W), .LEGACY(1'b1), .MUL_ITERATIVE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .issue_i(issue), .op_i(op), .src_a_i(a), .src_b_i(b),
        .busy_o(busy_a), .rd_valid_o(rv_a), .rd_data_o(rd_a), .rd_undef_o(ru_a),
        .hazard_o(hz_a)
    );

    hilo_unit #(.W(W), .LEGACY(1'b0), .MUL_ITERATIVE(1'b0)) dut_m (
        .clk(clk), .rst(rst), .issue_i(issue), .op_i(op), .src_a_i(a), .src_b_i(b),
        .busy_o(busy_m), .rd_valid_o(rv_m), .rd_data_o(rd_m), .rd_undef_o(ru_m),
        .hazard_o(hz_m)
    );

    typedef struct packed {
        logic [2:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 32'd3,          32'd5,          32'd0,          32'd15},
        '{3'd1, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'hFFFF_FFFE,  32'h0000_0001},
        '{3'd1, 32'h8000_0000,  32'd2,          32'd1,          32'd0},
        '{3'd1, 32'h1234_5678,  32'h0001_0000,  32'h0000_1234,  32'h5678_0000},
        '{3'd2, 32'd100,        32'd7,          32'd2,          32'd14},
        '{3'd2, 32'hFFFF_FFFF,  32'd1,          32'd0,          32'hFFFF_FFFF},
        '{3'd2, 32'd5,          32'd9,          32'd5,          32'd0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        while (busy_a || busy_m) @(negedge clk);
        issue = 1'b1; op = o; a = x; b = y;
        @(negedge clk);
        issue = 1'b0; op = 3'd0;
        c_rv_a = rv_a; c_rd_a = rd_a; c_ru_a = ru_a; c_hz_a = hz_a;
        c_rv_m = rv_m; c_rd_m = rd_m; c_ru_m = ru_m; c_hz_m = hz_m;
    endtask

    task automatic rd_check(input logic [2:0] o, input string req,
                            input logic [W-1:0] exp, input logic exp_u);
        do_op(o, '0, '0);
        check({req, " valid"},     {63'd0, c_rv_a}, 64'd1);
        check({req, " data"},      {32'd0, c_rd_a}, {32'd0, exp});
        check({req, " undef"},     {63'd0, c_ru_a}, {63'd0, exp_u});
        check({req, " data(m)"},   {32'd0, c_rd_m}, {32'd0, exp});
        check({req, " undef(m)"},  {63'd0, c_ru_m}, {63'd0, exp_u});
    endtask

    task automatic busy_len(output int na, output int nm);
        na = 0; nm = 0;
        while (busy_a || busy_m) begin
            if (busy_a) na++;
            if (busy_m) nm++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int na, nm, waits;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 busy after reset", {63'd0, busy_a}, 64'd0);
        check("R1 hazard after reset", {63'd0, hz_a}, 64'd0);
        rd_check(OP_GETHI, "R1 HI reset", 32'd0, 1'b0);
        rd_check(OP_GETLO, "R1 LO reset", 32'd0, 1'b0);

        // R2 / R3: vector table
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].a, VECS[i].b);
            rd_check(OP_GETHI, (VECS[i].op == 3'd1) ? "R2 mul HI" : "R3 div HI", VECS[i].hi, 1'b0);
            rd_check(OP_GETLO, (VECS[i].op == 3'd1) ? "R2 mul LO" : "R3 div LO", VECS[i].lo, 1'b0);
        end

        // R12 / R3: busy lengths
        do_op(OP_MULU, 32'd7, 32'd9);
        busy_len(na, nm);
        check("R12 iterative mul busy", na, W);
        check("R12 fast mul busy", nm, 1);
        do_op(OP_DIVU, 32'd77, 32'd8);
        busy_len(na, nm);
        check("R3 div busy (iter build)", na, W);
        check("R3 div busy (fast build)", nm, W);

        // R6: move to HI over an unread result
        do_op(OP_MULU, 32'd2, 32'd3);
        do_op(OP_SETHI, 32'hAA, '0);
        do_op(OP_GETLO, '0, '0);
        check("R6 LO undef", {63'd0, c_ru_a}, 64'd1);
        check("R6 LO undef(m)", {63'd0, c_ru_m}, 64'd1);
        rd_check(OP_GETHI, "R4 HI move", 32'hAA, 1'b0);

        // R7: move to LO over an unread result
        do_op(OP_DIVU, 32'd20, 32'd6);
        do_op(OP_SETLO, 32'h55, '0);
        do_op(OP_GETHI, '0, '0);
        check("R7 HI undef", {63'd0, c_ru_a}, 64'd1);
        rd_check(OP_GETLO, "R4 LO move", 32'h55, 1'b0);

        // R8 / R5: read consumes the result, later move is clean
        do_op(OP_MULU, 32'd4, 32'd5);
        rd_check(OP_GETHI, "R5 consume read", 32'd0, 1'b0);
        do_op(OP_SETHI, 32'd7, '0);
        rd_check(OP_GETLO, "R8 LO defined", 32'd20, 1'b0);

        // R9: divide by zero
        do_op(OP_DIVU, 32'd1234, 32'd0);
        busy_len(na, nm);
        check("R9 div0 busy", na, W);
        rd_check(OP_GETLO, "R9 div0 LO", 32'hFFFF_FFFF, 1'b1);
        rd_check(OP_GETHI, "R9 div0 HI", 32'd1234, 1'b1);
        do_op(OP_SETHI, 32'd9, '0);
        rd_check(OP_GETHI, "R4 undef cleared", 32'd9, 1'b0);
        rd_check(OP_GETLO, "R9 LO still undef", 32'hFFFF_FFFF, 1'b1);

        // R10: read held through busy
        do_op(OP_DIVU, 32'd50, 32'd5);
        issue = 1'b1; op = OP_GETLO;
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!rv_a && waits < 100);
        check("R10 stall latency", waits, W + 1);
        check("R10 stalled read data", {32'd0, rd_a}, 64'd10);
        issue = 1'b0; op = 3'd0;
        @(negedge clk);

        // R11: legacy spacing hazard
        do_op(OP_IDLE, '0, '0);
        do_op(OP_IDLE, '0, '0);
        do_op(OP_GETHI, '0, '0);
        do_op(OP_SETHI, 32'd1, '0);
        check("R11 write right after read", {63'd0, c_hz_a}, 64'd1);
        check("R11 modern build quiet", {63'd0, c_hz_m}, 64'd0);
        do_op(OP_IDLE, '0, '0);
        do_op(OP_IDLE, '0, '0);
        do_op(OP_GETLO, '0, '0);
        do_op(OP_IDLE, '0, '0);
        do_op(OP_SETLO, 32'd2, '0);
        check("R11 write one apart", {63'd0, c_hz_a}, 64'd1);
        do_op(OP_IDLE, '0, '0);
        do_op(OP_IDLE, '0, '0);
        do_op(OP_GETLO, '0, '0);
        do_op(OP_IDLE, '0, '0);
        do_op(OP_IDLE, '0, '0);
        do_op(OP_SETLO, 32'd3, '0);
        check("R11 write two apart", {63'd0, c_hz_a}, 64'd0);

        // R1: reset clears history and registers
        do_op(OP_GETHI, '0, '0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_op(OP_SETHI, 32'd4, '0);
        check("R1 history cleared", {63'd0, c_hz_a}, 64'd0);
        rd_check(OP_GETLO, "R1 LO after reset", 32'd0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule